// File: doc/BRIEF.md
# Programmable DRAM Refresh Scheduler

This block paces auto-refresh for a DDR memory controller. A 3-bit interval code selects one of three refresh periods. A separate enable bit turns the timer on once the controller's initialisation sequence has reached normal operation. The timer counts clock cycles against a clock-frequency parameter given in MHz. Each expired interval adds one to a pending count, and the block asks the command arbiter for a refresh whenever that count is non-zero. When the arbiter acknowledges, the count drops by one and every other command is held off for a programmable refresh cycle time.

A second, independent path merges the refresh needs of the installed memory modules into a single interval code for the controller. Each present module reports a refresh-class index. The merge chooses the strictest requirement using a fixed ranking, not by numeric order of the codes, and it flags indices that cannot be supported.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high and on the first sample after it falls: `ref_req`=0, `ref_urgent`=0, `cmd_block`=0, `pend_cnt`=0, `merged_mode`=3'b001, `merge_err`=0.
- R2: The interval codes on `rf_mode` are 3'b001 = 15.6 µs (CLK_MHZ*156/10 cycles), 3'b010 = 7.8 µs (CLK_MHZ*78/10 cycles) and 3'b011 = 64 µs (CLK_MHZ*64 cycles). After enabling from the stopped state, `pend_cnt` becomes 1 and `ref_req` rises exactly that many enabled clock edges later, and not one edge sooner.
- R3: While `rf_en`=0, or `rf_mode` is 3'b000 or a reserved code (3'b1xx), the timer is stopped, `pend_cnt` clears on the next edge, and no request is raised.
- R4: Missed intervals accumulate in `pend_cnt`, which saturates at PEND_MAX (8). `ref_urgent` is 1 exactly when `pend_cnt` equals PEND_MAX.
- R5: An acknowledge on `ref_ack` counts only while `ref_req`=1. It lowers `pend_cnt` by one on that edge.
- R6: After an accepted acknowledge, `cmd_block` is 1 for exactly 14 - `trfc_code` cycles (code 0 gives 14 cycles, code 7 gives 7 cycles). `ref_req` stays 0 while `cmd_block` is 1.
- R7: An acknowledge while `ref_req`=0 has no effect: `cmd_block` stays 0 and `pend_cnt` is unchanged.
- R8: Module refresh-class mapping (4-bit field i at `mod_class[4*i+3:4*i]`): class 2 maps to 7.8 µs (3'b010); classes 0, 3, 4 and 5 map to 15.6 µs (3'b001). With no module present, `merged_mode` is 3'b001.
- R9: A present module with class 1 or a class above 5 sets `merge_err`. Modules whose `mod_present` bit is 0 are ignored, whatever their class field holds.
- R10: The merge ranks codes from least to most strict as 3'b000, 3'b011, 3'b001, 3'b010. The strictest code among the default and all present modules wins, regardless of which slot holds it.
- R11: `merged_mode` and `merge_err` are registered and follow their inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_en | input | 1 | Global refresh enable |
| rf_mode | input | 3 | Refresh interval code |
| trfc_code | input | 3 | Refresh cycle time code (hold-off = 14 - code cycles) |
| ref_ack | input | 1 | Arbiter acknowledge of a refresh request |
| mod_present | input | N_MOD | One bit per installed module |
| mod_class | input | N_MOD*IDX_W | Refresh-class index per module, 4 bits each |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_urgent | output | 1 | Pending count has reached its limit |
| cmd_block | output | 1 | Hold off all other commands |
| pend_cnt | output | PW | Number of owed refreshes |
| merged_mode | output | 3 | Interval code merged from modules |
| merge_err | output | 1 | A present module has an unsupported class |

## Verification
The bench builds the block with CLK_MHZ=1 and N_MOD=4, which sets the three intervals to 15, 7 and 64 cycles. At those lengths the exact first-request edge can be checked for every legal code. Eight missed 7-cycle intervals reach saturation in 56 cycles. A full 14-cycle hold-off fits inside a 64-cycle interval, so no new request lands during it. Four module slots are enough to show that the ranking wins regardless of slot order, and that an absent slot holding a bad class is ignored.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_156 = 3'b001;
  localparam logic [2:0] MODE_78  = 3'b010;
  localparam logic [2:0] MODE_64  = 3'b011;

  // Strictness rank used when merging module needs.
  function automatic logic [1:0] mode_rank(input logic [2:0] m);
    case (m)
      MODE_64:  mode_rank = 2'd1;
      MODE_156: mode_rank = 2'd2;
      MODE_78:  mode_rank = 2'd3;
      default:  mode_rank = 2'd0;
    endcase
  endfunction

  function automatic logic class_bad(input logic [7:0] idx);
    class_bad = (idx == 8'd1) || (idx > 8'd5);
  endfunction

  function automatic logic [2:0] class_mode(input logic [7:0] idx);
    case (idx)
      8'd2:                   class_mode = MODE_78;
      8'd0, 8'd3, 8'd4, 8'd5: class_mode = MODE_156;
      default:                class_mode = MODE_OFF;
    endcase
  endfunction

  function automatic logic mode_legal(input logic [2:0] m);
    mode_legal = (m == MODE_156) || (m == MODE_78) || (m == MODE_64);
  endfunction
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int CLK_MHZ = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [2:0] mode,
  output logic       tick
);
  import rfsh_pkg::*;
  localparam int LIM_156 = CLK_MHZ * 156 / 10;
  localparam int LIM_78  = CLK_MHZ * 78 / 10;
  localparam int LIM_64  = CLK_MHZ * 64;
  localparam int CW      = $clog2(LIM_64 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    case (mode)
      MODE_156: lim = CW'(LIM_156);
      MODE_78:  lim = CW'(LIM_78);
      default:  lim = CW'(LIM_64);
    endcase
  end

  // >= lets a switch to a shorter interval expire at once.
  assign tick = active && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !active || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int PEND_MAX  = 8,
  parameter int TRFC_BASE = 14,
  parameter int PW        = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          tick,
  input  logic          ack,
  input  logic [2:0]    trfc_code,
  output logic          ref_req,
  output logic          urgent,
  output logic          block,
  output logic [PW-1:0] pend
);
  localparam int BW = $clog2(TRFC_BASE + 1);

  logic [PW-1:0] pend_q, pend_n;
  logic [BW-1:0] busy_q;
  logic          take, inc;

  assign ref_req = (pend_q != '0) && (busy_q == '0);
  assign take    = ack && ref_req;
  assign inc     = tick && ((pend_q != PW'(PEND_MAX)) || take);

  always_comb begin
    pend_n = pend_q;
    if (inc)     pend_n = pend_n + PW'(1);
    if (take)    pend_n = pend_n - PW'(1);
    if (!active) pend_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      busy_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (take)              busy_q <= BW'(TRFC_BASE) - BW'(trfc_code);
      else if (busy_q != '0) busy_q <= busy_q - BW'(1);
    end
  end

  assign urgent = (pend_q == PW'(PEND_MAX));
  assign block  = (busy_q != '0);
  assign pend   = pend_q;
endmodule

// File: rtl/rfsh_merge.sv
module rfsh_merge #(
  parameter int N_MOD = 4,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_MOD-1:0]       present,
  input  logic [N_MOD*IDX_W-1:0] cls,
  output logic [2:0]             mode_o,
  output logic                   err_o
);
  import rfsh_pkg::*;

  logic [2:0] best;
  logic       bad;

  always_comb begin
    best = MODE_156;
    bad  = 1'b0;
    for (int i = 0; i < N_MOD; i++) begin
      if (present[i]) begin
        if (class_bad(8'(cls[i*IDX_W +: IDX_W]))) bad = 1'b1;
        if (mode_rank(class_mode(8'(cls[i*IDX_W +: IDX_W]))) > mode_rank(best))
          best = class_mode(8'(cls[i*IDX_W +: IDX_W]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_156;
      err_o  <= 1'b0;
    end else begin
      mode_o <= best;
      err_o  <= bad;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_MHZ   = 200,
  parameter int PEND_MAX  = 8,
  parameter int TRFC_BASE = 14,
  parameter int N_MOD     = 4,
  parameter int IDX_W     = 4,
  parameter int PW        = $clog2(PEND_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rf_en,
  input  logic [2:0]             rf_mode,
  input  logic [2:0]             trfc_code,
  input  logic                   ref_ack,
  input  logic [N_MOD-1:0]       mod_present,
  input  logic [N_MOD*IDX_W-1:0] mod_class,
  output logic                   ref_req,
  output logic                   ref_urgent,
  output logic                   cmd_block,
  output logic [PW-1:0]          pend_cnt,
  output logic [2:0]             merged_mode,
  output logic                   merge_err
);
  import rfsh_pkg::*;

  logic active, tick;

  assign active = rf_en && mode_legal(rf_mode);

  rfsh_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
    .clk(clk), .rst(rst), .active(active), .mode(rf_mode), .tick(tick)
  );

  rfsh_pend #(.PEND_MAX(PEND_MAX), .TRFC_BASE(TRFC_BASE), .PW(PW)) u_pend (
    .clk(clk), .rst(rst), .active(active), .tick(tick), .ack(ref_ack),
    .trfc_code(trfc_code), .ref_req(ref_req), .urgent(ref_urgent),
    .block(cmd_block), .pend(pend_cnt)
  );

  rfsh_merge #(.N_MOD(N_MOD), .IDX_W(IDX_W)) u_merge (
    .clk(clk), .rst(rst), .present(mod_present), .cls(mod_class),
    .mode_o(merged_mode), .err_o(merge_err)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int PEND_MAX = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rf_en,
  input logic          ref_ack,
  input logic          ref_req,
  input logic          cmd_block,
  input logic [PW-1:0] pend_cnt,
  input logic [2:0]    merged_mode
);
  p_pend_bound_r4: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= PW'(PEND_MAX));

  p_pend_step_r5: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= $past(pend_cnt) + PW'(1));

  p_off_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !rf_en |=> (pend_cnt == '0));

  p_block_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (ref_ack && ref_req) |=> cmd_block);

  p_no_req_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_block |-> !ref_req);

  p_ignored_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_ack && !ref_req && !cmd_block) |=> !cmd_block);

  p_merge_legal_r8: assert property (@(posedge clk) disable iff (rst)
    (merged_mode == 3'b001) || (merged_mode == 3'b010));
endmodule

bind refresh_sched refresh_sched_chk #(.PEND_MAX(PEND_MAX), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .rf_en(rf_en), .ref_ack(ref_ack), .ref_req(ref_req),
  .cmd_block(cmd_block), .pend_cnt(pend_cnt), .merged_mode(merged_mode)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int N_MOD = 4;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rf_en = 1'b0;
  logic [2:0] rf_mode = 3'b000;
  logic [2:0] trfc_code = 3'b000;
  logic ref_ack = 1'b0;
  logic [N_MOD-1:0] mod_present = '0;
  logic [N_MOD*IDX_W-1:0] mod_class = '0;
  logic ref_req, ref_urgent, cmd_block, merge_err;
  logic [3:0] pend_cnt;
  logic [2:0] merged_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(.CLK_MHZ(1), .N_MOD(N_MOD), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .rf_en(rf_en), .rf_mode(rf_mode),
    .trfc_code(trfc_code), .ref_ack(ref_ack), .mod_present(mod_present),
    .mod_class(mod_class), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .cmd_block(cmd_block), .pend_cnt(pend_cnt), .merged_mode(merged_mode),
    .merge_err(merge_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stop_timer();
    rf_en = 1'b0;
    ref_ack = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req in reset", ref_req, 0);
    chk("R1 block in reset", cmd_block, 0);
    rst = 1'b0;
    step(1);
    chk("R1 req", ref_req, 0);
    chk("R1 urgent", ref_urgent, 0);
    chk("R1 block", cmd_block, 0);
    chk("R1 pend", pend_cnt, 0);
    chk("R1 merged", merged_mode, 1);
    chk("R1 err", merge_err, 0);
  endtask

  task automatic t_interval(input logic [2:0] m, input int lim);
    stop_timer();
    rf_mode = m;
    rf_en = 1'b1;
    step(lim - 1);
    chk("R2 no request before interval", pend_cnt, 0);
    chk("R2 req low before interval", ref_req, 0);
    step(1);
    chk("R2 pend after interval", pend_cnt, 1);
    chk("R2 req after interval", ref_req, 1);
    rf_en = 1'b0;
    step(1);
    chk("R3 enable low clears", pend_cnt, 0);
    chk("R3 no req when off", ref_req, 0);
  endtask

  task automatic t_saturate();
    stop_timer();
    rf_mode = 3'b010;
    rf_en = 1'b1;
    step(49);
    chk("R4 seven pending", pend_cnt, 7);
    chk("R4 not urgent at 7", ref_urgent, 0);
    step(7);
    chk("R4 eight pending", pend_cnt, 8);
    chk("R4 urgent at 8", ref_urgent, 1);
    step(20);
    chk("R4 saturated", pend_cnt, 8);
    rf_mode = 3'b000;
    step(1);
    chk("R3 disabled code clears", pend_cnt, 0);
    chk("R3 urgent drops", ref_urgent, 0);
  endtask

  task automatic t_ack(input logic [2:0] code);
    int t;
    t = 14 - int'(code);
    stop_timer();
    trfc_code = code;
    rf_mode = 3'b011;
    rf_en = 1'b1;
    step(64);
    chk("R5 req before ack", ref_req, 1);
    ref_ack = 1'b1;
    step(1);
    ref_ack = 1'b0;
    chk("R5 pend after ack", pend_cnt, 0);
    chk("R6 block after ack", cmd_block, 1);
    chk("R6 req low while blocked", ref_req, 0);
    step(t - 1);
    chk("R6 block last cycle", cmd_block, 1);
    step(1);
    chk("R6 block released", cmd_block, 0);
  endtask

  task automatic t_ack_ignored();
    stop_timer();
    rf_mode = 3'b011;
    rf_en = 1'b1;
    ref_ack = 1'b1;
    step(3);
    ref_ack = 1'b0;
    chk("R7 no block from stray ack", cmd_block, 0);
    chk("R7 pend unchanged", pend_cnt, 0);
    step(61);
    chk("R7 timer request unaffected", pend_cnt, 1);
    chk("R7 req unaffected", ref_req, 1);
  endtask

  task automatic t_reserved();
    stop_timer();
    rf_mode = 3'b101;
    rf_en = 1'b1;
    step(80);
    chk("R3 reserved code no pend", pend_cnt, 0);
    chk("R3 reserved code no req", ref_req, 0);
    rf_mode = 3'b010;
    step(14);
    chk("R2 two intervals pend", pend_cnt, 2);
    rf_mode = 3'b111;
    step(1);
    chk("R3 reserved clears pend", pend_cnt, 0);
  endtask

  task automatic set_cls(input int slot, input int v);
    mod_class[slot*IDX_W +: IDX_W] = IDX_W'(v);
  endtask

  task automatic t_merge();
    mod_present = '0;
    step(1);
    chk("R8 none present default", merged_mode, 1);
    mod_present = 4'b0001;
    set_cls(0, 2);
    step(1);
    chk("R8 class 2 maps 7.8", merged_mode, 2);
    set_cls(0, 3);
    chk("R11 output holds before edge", merged_mode, 2);
    step(1);
    chk("R8 class 3 maps 15.6", merged_mode, 1);
    chk("R9 class 3 no error", merge_err, 0);
    set_cls(0, 0);
    step(1);
    chk("R8 class 0 maps 15.6", merged_mode, 1);
    mod_present = 4'b0011;
    set_cls(1, 1);
    step(1);
    chk("R9 class 1 error", merge_err, 1);
    chk("R9 class 1 mode", merged_mode, 1);
    mod_present = 4'b0001;
    set_cls(1, 6);
    chk("R11 err holds before edge", merge_err, 1);
    step(1);
    chk("R9 absent bad class ignored", merge_err, 0);
    mod_present = 4'b1001;
    set_cls(3, 7);
    step(1);
    chk("R9 class 7 error", merge_err, 1);
    mod_present = 4'b0101;
    set_cls(0, 5);
    set_cls(2, 2);
    step(1);
    chk("R10 strictest wins high slot", merged_mode, 2);
    chk("R9 no error", merge_err, 0);
    set_cls(0, 2);
    set_cls(2, 4);
    step(1);
    chk("R10 strictest wins low slot", merged_mode, 2);
  endtask

  initial begin
    t_reset();
    t_interval(3'b001, 15);
    t_interval(3'b010, 7);
    t_interval(3'b011, 64);
    t_saturate();
    t_ack(3'b000);
    t_ack(3'b111);
    t_ack_ignored();
    t_reserved();
    t_merge();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule